// File: doc/BRIEF.md
# Oscillator Startup Delay Timer

This block keeps the CPU clock switched off after the oscillator is started again, until the oscillator has had time to settle. A 10-bit synchronous counter runs on the raw oscillator clock. Two events restart it: the asynchronous power-monitor reset, and a restart request raised when the part leaves power-down. When the counter has counted a settling window, it raises `clkValid`. The downstream clock divider uses `clkValid` as its enable, so no oscillator edge reaches the CPU before then.

A select input chooses the window: 256 oscillator cycles for a short delay or 1024 for a long one. The select is captured once, on the edge that arms the count, and is held for the whole count. When the window has run out, the counter stops and `clkValid` stays high until the next restart.

Top module: `osc_settle_timer`

## Requirements
- R1: While `rstN` is low, `clkValid` is low. The first `oscClk` rising edge after `rstN` is released is the arm edge: it clears the counter and captures `longSel`.
- R2: With `longSel` = 0 captured at the arm edge, `clkValid` is low after 255 further rising edges and high after 256.
- R3: With `longSel` = 1 captured at the arm edge, `clkValid` is low after 1023 further rising edges and high after 1024.
- R4: Once `clkValid` is high, it stays high on every later edge until `restartReq` is raised again.
- R5: While `restartReq` is high, `clkValid` is low in the same cycle, without waiting for a clock edge.
- R6: A rising edge that samples `restartReq` high while a count is running is a new arm edge, and the full delay starts again from zero.
- R7: Changes on `longSel` after the arm edge have no effect on the length of the current delay.
- R8: A restart while `clkValid` is high re-arms the timer, and the new delay uses the `longSel` value sampled at that restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| oscClk | input | 1 | Raw oscillator clock |
| rstN | input | 1 | Power-monitor reset, asynchronous, active low |
| restartReq | input | 1 | Restart request on exit from power-down, synchronous to `oscClk` |
| longSel | input | 1 | Delay select: 1 = 1024 cycles, 0 = 256 cycles |
| clkValid | output | 1 | High when the oscillator may be passed to the CPU clock divider |

## Verification
The assertions assume that `restartReq` and `longSel` are synchronous to `oscClk` and change only away from its rising edge. They also assume that `rstN` is asserted at time zero. The bench drives every input on the falling edge and holds reset from the start. Its random stimulus includes restarts of any length, `longSel` toggling on every cycle during a count, and restarts landing at random points inside a running window.

// File: rtl/osc_settle_pkg.sv
package osc_settle_pkg;

  // Control states: arm pending, counting, settled
  typedef enum logic [1:0] {
    ST_ARM  = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } settleState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic arm;   // clear counter, capture delay select
    logic step;  // advance counter by one
  } settleStrobe_t;

endpackage

// File: rtl/osc_settle_dp.sv
module osc_settle_dp
  import osc_settle_pkg::*;
#(
  parameter int SHORT_CYCLES = 256,
  parameter int LONG_CYCLES  = 1024,
  localparam int CW = $clog2(LONG_CYCLES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          longSel,
  input  settleStrobe_t strobe,
  output logic [CW-1:0] countQ,
  output logic          selLongQ,
  output logic          atTerm
);

  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYCLES - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYCLES - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ   <= '0;
      selLongQ <= 1'b0;
    end else if (strobe.arm) begin
      countQ   <= '0;
      selLongQ <= longSel;
    end else if (strobe.step) begin
      countQ   <= countQ + 1'b1;
    end
  end

  // Terminal detect uses the captured select only
  always_comb begin
    atTerm = (countQ == (selLongQ ? LONG_LAST : SHORT_LAST));
  end

endmodule

// File: rtl/osc_settle_ctrl.sv
module osc_settle_ctrl
  import osc_settle_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          restartReq,
  input  logic          atTerm,
  output settleStrobe_t strobe,
  output settleState_t  stateQ,
  output logic          validQ
);

  settleState_t stateD;

  always_comb begin
    strobe.arm  = restartReq || (stateQ == ST_ARM);
    strobe.step = !strobe.arm && (stateQ == ST_RUN) && !atTerm;
    stateD      = stateQ;
    if (strobe.arm) begin
      stateD = ST_RUN;
    end else if (stateQ == ST_RUN && atTerm) begin
      stateD = ST_DONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_ARM;
    end else begin
      stateQ <= stateD;
    end
  end

  always_comb begin
    validQ = (stateQ == ST_DONE);
  end

endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer
  import osc_settle_pkg::*;
#(
  parameter int SHORT_CYCLES = 256,
  parameter int LONG_CYCLES  = 1024
) (
  input  logic oscClk,
  input  logic rstN,
  input  logic restartReq,
  input  logic longSel,
  output logic clkValid
);

  localparam int CW = $clog2(LONG_CYCLES);

  settleStrobe_t strobe;
  settleState_t  stateQ;
  logic [CW-1:0] countQ;
  logic          selLongQ;
  logic          atTerm;
  logic          validQ;

  osc_settle_ctrl ctrl_i (
    .clk        (oscClk),
    .rstN       (rstN),
    .restartReq (restartReq),
    .atTerm     (atTerm),
    .strobe     (strobe),
    .stateQ     (stateQ),
    .validQ     (validQ)
  );

  osc_settle_dp #(
    .SHORT_CYCLES (SHORT_CYCLES),
    .LONG_CYCLES  (LONG_CYCLES)
  ) dp_i (
    .clk      (oscClk),
    .rstN     (rstN),
    .longSel  (longSel),
    .strobe   (strobe),
    .countQ   (countQ),
    .selLongQ (selLongQ),
    .atTerm   (atTerm)
  );

  // A restart request masks the enable at once, before any edge
  assign clkValid = validQ && !restartReq;

endmodule

// File: rtl/osc_settle_timer_chk.sv
module osc_settle_timer_chk
  import osc_settle_pkg::*;
#(
  parameter int SHORT_CYCLES = 256,
  parameter int LONG_CYCLES  = 1024,
  localparam int CW = $clog2(LONG_CYCLES)
) (
  input logic          oscClk,
  input logic          rstN,
  input logic          restartReq,
  input logic          clkValid,
  input logic          validQ,
  input settleState_t  stateQ,
  input logic [CW-1:0] countQ,
  input logic          selLongQ
);

  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYCLES - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYCLES - 1);

  always_comb begin
    if (!rstN) begin
      AST_RESET_LOW: assert (!clkValid); // R1
    end
  end

  AST_RESTART_MASKS: assert property (@(posedge oscClk) disable iff (!rstN)
    restartReq |-> !clkValid); // R5

  AST_RESTART_CLEARS: assert property (@(posedge oscClk) disable iff (!rstN)
    restartReq |=> (countQ == '0 && !validQ)); // R6

  AST_VALID_STICKY: assert property (@(posedge oscClk) disable iff (!rstN)
    (validQ && !restartReq) |=> validQ); // R4

  AST_COUNT_FROZEN: assert property (@(posedge oscClk) disable iff (!rstN)
    (validQ && !restartReq) |=> $stable(countQ)); // R4

  AST_SEL_HELD: assert property (@(posedge oscClk) disable iff (!rstN)
    (!restartReq && stateQ != ST_ARM) |=> $stable(selLongQ)); // R7

  AST_VALID_AT_TERM: assert property (@(posedge oscClk) disable iff (!rstN)
    $rose(validQ) |-> (countQ == (selLongQ ? LONG_LAST : SHORT_LAST))); // R2 R3

endmodule

bind osc_settle_timer osc_settle_timer_chk #(
  .SHORT_CYCLES (SHORT_CYCLES),
  .LONG_CYCLES  (LONG_CYCLES)
) chk_i (
  .oscClk     (oscClk),
  .rstN       (rstN),
  .restartReq (restartReq),
  .clkValid   (clkValid),
  .validQ     (validQ),
  .stateQ     (stateQ),
  .countQ     (countQ),
  .selLongQ   (selLongQ)
);

// File: tb/osc_settle_timer_tb_top.sv
`timescale 1ns/1ps
module osc_settle_timer_tb_top;

  localparam int SHORT_CYCLES = 256;
  localparam int LONG_CYCLES  = 1024;

  logic oscClk = 1'b0;
  logic rstN = 1'b0;
  logic restartReq = 1'b0;
  logic longSel = 1'b0;
  logic clkValid;

  int checks = 0;
  int errors = 0;

  always #4 oscClk = ~oscClk;  // 125 MHz

  osc_settle_timer #(
    .SHORT_CYCLES (SHORT_CYCLES),
    .LONG_CYCLES  (LONG_CYCLES)
  ) dut_i (
    .oscClk     (oscClk),
    .rstN       (rstN),
    .restartReq (restartReq),
    .longSel    (longSel),
    .clkValid   (clkValid)
  );

  function automatic int delayOf(input logic sel);
    return sel ? LONG_CYCLES : SHORT_CYCLES;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: clkValid=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive a restart across one rising edge; returns at the following falling edge
  task automatic doRestart(input logic sel, input string req);
    restartReq = 1'b1;
    longSel    = sel;
    #1;
    check("R5", clkValid, 1'b0);
    @(negedge oscClk);
    restartReq = 1'b0;
    longSel    = $urandom_range(0, 1);
    check(req, clkValid, 1'b0);
  endtask

  // Count the window from the arm edge, scrambling longSel every cycle
  task automatic expectDelay(input int n, input string req);
    for (int i = 1; i < n; i++) begin
      @(negedge oscClk);
      longSel = $urandom_range(0, 1);  // R7
    end
    check(req, clkValid, 1'b0);
    @(negedge oscClk);
    check(req, clkValid, 1'b1);
  endtask

  task automatic holdValid(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge oscClk);
      longSel = $urandom_range(0, 1);
      check("R4", clkValid, 1'b1);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0c17));
    #3;
    check("R1", clkValid, 1'b0);
    repeat (3) @(negedge oscClk);
    check("R1", clkValid, 1'b0);
    longSel = 1'b0;
    rstN    = 1'b1;
    @(negedge oscClk);  // arm edge has passed
    check("R1", clkValid, 1'b0);
    expectDelay(delayOf(1'b0), "R2");
    holdValid(20);

    // long delay from a restart out of the settled state
    @(negedge oscClk);
    doRestart(1'b1, "R8");
    expectDelay(delayOf(1'b1), "R3");
    holdValid(5);

    // short delay re-armed from settled
    @(negedge oscClk);
    doRestart(1'b0, "R8");
    expectDelay(delayOf(1'b0), "R2");

    // restart one cycle before the window runs out
    @(negedge oscClk);
    doRestart(1'b0, "R6");
    repeat (SHORT_CYCLES - 2) @(negedge oscClk);
    check("R6", clkValid, 1'b0);
    doRestart(1'b1, "R6");
    expectDelay(delayOf(1'b1), "R6");

    // a multi-cycle restart request keeps re-arming
    @(negedge oscClk);
    restartReq = 1'b1;
    longSel    = 1'b0;
    repeat (4) begin
      @(negedge oscClk);
      check("R5", clkValid, 1'b0);
    end
    restartReq = 1'b0;
    expectDelay(delayOf(1'b0), "R2");

    // random trials: random select, optional interruption mid-count
    for (int t = 0; t < 24; t++) begin
      logic sel;
      sel = 1'(($urandom & 1));
      @(negedge oscClk);
      doRestart(sel, "R8");
      if (($urandom & 1) == 1) begin
        int k;
        k = $urandom_range(1, delayOf(sel) - 2);
        repeat (k) begin
          @(negedge oscClk);
          longSel = $urandom_range(0, 1);
        end
        check("R6", clkValid, 1'b0);
        sel = 1'(($urandom & 1));
        doRestart(sel, "R6");
      end
      expectDelay(delayOf(sel), sel ? "R3" : "R2");
      holdValid($urandom_range(1, 6));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule